// File: doc/BRIEF.md
# Free-Running LSB-First Serial Word Sender

This block turns a parallel word into a clocked two-wire serial stream (one data line, one clock line) and repeats that stream forever. Every frame begins after a programmable idle interval. The word length is chosen per frame as 8, 16 or 32 bits, and the least-significant bit goes out first. The serial clock rests high. For each bit, the clock stays high for one half-period. Then the new bit is driven and the clock goes low for one half-period, and then the clock returns high. A receiver takes each bit on the rising clock edge, or at any point in the low phase.

The control is one state machine with three states. GAP is the idle interval between frames. HIGH is the high half of a bit cell. LOW is the low half of a bit cell. The machine moves between them through four named transitions:

- start (GAP to HIGH) latches the word and the size select.
- fall (HIGH to LOW) drives the current bit and pulls the clock low.
- rise (LOW to HIGH) brings the clock high and moves to the next bit.
- finish (LOW to GAP) brings the clock high after the final bit and raises a one-cycle frame-done pulse.

A single countdown timer measures every state. Its limit is the gap length while in GAP and the half-period otherwise. A length of zero behaves like a length of one.

Top module: `lsb_serial_tx`

## Requirements
- R1: A synchronous active-high `rst` sets `sclk` to 1 and `sdata` to 0, holds `frame_done` at 0, and restarts the gap timer. After `rst` is released, timing starts with a fresh gap, as described in R3.
- R2: Outside a frame, `sclk` is 1. `sdata` may still carry the final bit only during the first gap cycle. From the second gap cycle up to the first falling edge of the next frame, including the first high phase, `sdata` is 0.
- R3: The gap lasts max(`gap_len`,1) cycles. The first falling edge of a frame therefore appears in cycle max(`gap_len`,1)+max(`half_per`,1)+1. Cycle 1 is the first gap cycle, which is the cycle in which `frame_done` is high, or the first cycle after reset.
- R4: `size_sel` encodes the word length as follows: 2'b00 selects 8 bits, 2'b01 selects 16 bits, and 2'b10 or 2'b11 selects 32 bits. A frame has exactly that many falling edges on `sclk`, and no trailing edge follows.
- R5: At the k-th falling edge of a frame (k counted from 0), `sdata` carries bit k of the captured word. Bits of `din` above the selected length are never sent.
- R6: Every high phase and every low phase of `sclk` inside a frame lasts max(`half_per`,1) system cycles.
- R7: `sdata` takes a new bit only in the cycle in which `sclk` falls. It keeps that value through the whole low phase.
- R8: `din` and `size_sel` are captured on the start transition, which is the last gap cycle. Changing them while a frame is in progress has no effect on that frame.
- R9: `frame_done` is high for exactly one cycle per frame. That cycle is the one in which `sclk` returns high after the final low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 32 | Word to send; bit 0 is sent first |
| size_sel | input | 2 | Word length: 00 for 8 bits, 01 for 16 bits, 1x for 32 bits |
| half_per | input | HALF_W (16) | Half-period of the serial clock, in system cycles |
| gap_len | input | GAP_W (16) | Idle interval before each frame, in system cycles |
| sdata | output | 1 | Serial data line |
| sclk | output | 1 | Serial clock line; rests high |
| frame_done | output | 1 | One-cycle pulse when a frame completes |

## Verification
The bound checker enforces the following on every cycle:
- the idle levels right after reset;
- that `frame_done` is a single-cycle pulse that lines up with a rising `sclk`;
- that `sdata` rises only together with a falling `sclk`;
- that the data line is low in the cycle after `frame_done`.

Several properties can only be shown by the bench's scenarios, because each needs a word and its length to be known ahead of time:
- the bit order and the exact number of falling edges per frame;
- the length of each phase and of the gap, including the zero-means-one cases;
- that the masked upper bits are never sent;
- that changes made in the middle of a frame are ignored;
- that a reset in the middle of a frame restarts the gap cleanly.

// File: rtl/lsb_serial_tx_pkg.sv
package lsb_serial_tx_pkg;

    localparam int unsigned WORD_W = 32;

    typedef enum logic [1:0] {
        SZ_8   = 2'b00,
        SZ_16  = 2'b01,
        SZ_32  = 2'b10,
        SZ_32X = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        ST_GAP  = 2'b00,
        ST_HIGH = 2'b01,
        ST_LOW  = 2'b10
    } state_e;

endpackage

// File: rtl/lsb_serial_tx_timer.sv
module lsb_serial_tx_timer #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lim,
    output logic         expire
);
    logic [W-1:0] cnt_q;
    logic [W:0]   cnt_next;

    // A limit of zero expires on the first cycle, exactly like a limit of one.
    assign cnt_next = {1'b0, cnt_q} + (W+1)'(1);
    assign expire   = (cnt_next >= {1'b0, lim});

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (expire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + W'(1);
        end
    end
endmodule

// File: rtl/lsb_serial_tx_shifter.sv
module lsb_serial_tx_shifter
    import lsb_serial_tx_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic [1:0]   size_sel,
    input  logic         advance,
    output logic         lsb,
    output logic         last
);
    localparam int unsigned IDX_W = $clog2(W);

    logic [W-1:0]     sreg_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] top_q;
    logic [IDX_W-1:0] top_d;

    always_comb begin
        unique case (size_e'(size_sel))
            SZ_8:    top_d = IDX_W'(7);
            SZ_16:   top_d = IDX_W'(15);
            default: top_d = IDX_W'(W - 1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg_q <= '0;
            idx_q  <= '0;
            top_q  <= '0;
        end else if (load) begin
            sreg_q <= din;
            idx_q  <= '0;
            top_q  <= top_d;
        end else if (advance) begin
            sreg_q <= sreg_q >> 1;
            idx_q  <= idx_q + IDX_W'(1);
        end
    end

    assign lsb  = sreg_q[0];
    assign last = (idx_q == top_q);
endmodule

// File: rtl/lsb_serial_tx.sv
module lsb_serial_tx
    import lsb_serial_tx_pkg::*;
#(
    parameter int unsigned HALF_W = 16,
    parameter int unsigned GAP_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] din,
    input  logic [1:0]        size_sel,
    input  logic [HALF_W-1:0] half_per,
    input  logic [GAP_W-1:0]  gap_len,
    output logic              sdata,
    output logic              sclk,
    output logic              frame_done
);
    localparam int unsigned TMR_W = (HALF_W > GAP_W) ? HALF_W : GAP_W;

    state_e             state_q;
    state_e             state_d;
    logic [TMR_W-1:0]   lim;
    logic               expire;
    logic               bit_lsb;
    logic               bit_last;
    logic               t_start;
    logic               t_fall;
    logic               t_rise;
    logic               t_finish;

    assign lim = (state_q == ST_GAP) ? TMR_W'(gap_len) : TMR_W'(half_per);

    lsb_serial_tx_timer #(.W(TMR_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .lim    (lim),
        .expire (expire)
    );

    lsb_serial_tx_shifter #(.W(WORD_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (t_start),
        .din      (din),
        .size_sel (size_sel),
        .advance  (t_rise),
        .lsb      (bit_lsb),
        .last     (bit_last)
    );

    // Next state and named transitions
    always_comb begin
        state_d  = state_q;
        t_start  = 1'b0;
        t_fall   = 1'b0;
        t_rise   = 1'b0;
        t_finish = 1'b0;
        unique case (state_q)
            ST_GAP: begin
                if (expire) begin
                    state_d = ST_HIGH;
                    t_start = 1'b1;
                end
            end
            ST_HIGH: begin
                if (expire) begin
                    state_d = ST_LOW;
                    t_fall  = 1'b1;
                end
            end
            ST_LOW: begin
                if (expire && bit_last) begin
                    state_d  = ST_GAP;
                    t_finish = 1'b1;
                end else if (expire) begin
                    state_d = ST_HIGH;
                    t_rise  = 1'b1;
                end
            end
            default: state_d = ST_GAP;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_GAP;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            sclk       <= 1'b1;
            sdata      <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= t_finish;
            if (t_fall) begin
                sclk  <= 1'b0;
                sdata <= bit_lsb;
            end else if (t_rise || t_finish) begin
                sclk <= 1'b1;
            end
            if (state_q == ST_GAP) begin
                sdata <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/lsb_serial_tx_chk.sv
module lsb_serial_tx_chk (
    input logic clk,
    input logic rst,
    input logic sdata,
    input logic sclk,
    input logic frame_done
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        $fell(rst) |-> (sclk && !sdata && !frame_done));

    assert_gap_data_low_R2: assert property (@(posedge clk) disable iff (rst)
        $past(frame_done) |-> (sclk && !sdata));

    assert_data_rises_at_fall_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(sdata) |-> $fell(sclk));

    assert_done_with_rise_R9: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (sclk && !$past(sclk)));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);
endmodule

bind lsb_serial_tx lsb_serial_tx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .sdata      (sdata),
    .sclk       (sclk),
    .frame_done (frame_done)
);

// File: tb/lsb_serial_tx_bench.sv
module lsb_serial_tx_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] din;
    logic [1:0]  size_sel;
    logic [15:0] half_per;
    logic [15:0] gap_len;
    logic        sdata;
    logic        sclk;
    logic        frame_done;

    always #5 clk = ~clk;

    lsb_serial_tx u_lsb_serial_tx (
        .clk        (clk),
        .rst        (rst),
        .din        (din),
        .size_sel   (size_sel),
        .half_per   (half_per),
        .gap_len    (gap_len),
        .sdata      (sdata),
        .sclk       (sclk),
        .frame_done (frame_done)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cur_h;
    int cur_g;
    bit exp_q[$];
    bit tag_q[$];
    int len_q[$];

    // monitor state
    bit prev_sclk = 1'b1;
    bit held      = 1'b0;
    bit in_frame  = 1'b0;
    int phase_cnt = 1;
    int since_gap = 1;
    int edges     = 0;

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int nbits(input logic [1:0] s);
        return (s == 2'b00) ? 8 : (s == 2'b01) ? 16 : 32;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst) begin
            exp_q.delete();
            tag_q.delete();
            len_q.delete();
            since_gap = 1;
            prev_sclk = 1'b1;
            phase_cnt = 1;
            edges     = 0;
            in_frame  = 1'b0;
        end else begin
            since_gap++;
            if (prev_sclk && !sclk) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4", "unexpected falling edge", edges, -1);
                end else begin
                    bit b;
                    bit t;
                    b = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(sdata == b, t ? "R8" : "R5", "bit value", int'(sdata), int'(b));
                end
                if (edges == 0)
                    chk(since_gap == eff(cur_g) + eff(cur_h) + 1, "R3", "first fall cycle",
                        since_gap, eff(cur_g) + eff(cur_h) + 1);
                else
                    chk(phase_cnt == eff(cur_h), "R6", "high phase length", phase_cnt, eff(cur_h));
                edges++;
                in_frame  = 1'b1;
                held      = sdata;
                phase_cnt = 1;
            end else if (!prev_sclk && sclk) begin
                chk(phase_cnt == eff(cur_h), "R6", "low phase length", phase_cnt, eff(cur_h));
                phase_cnt = 1;
            end else begin
                phase_cnt++;
                if (!sclk)
                    chk(sdata == held, "R7", "data held in low phase", int'(sdata), int'(held));
                if (sclk && !in_frame && since_gap >= 2)
                    chk(sdata == 1'b0, "R2", "idle data level", int'(sdata), 0);
            end
            if (frame_done) begin
                chk(!prev_sclk && sclk, "R9", "done with clock rise", int'(sclk), 1);
                if (len_q.size() == 0) begin
                    chk(1'b0, "R9", "unexpected frame_done", edges, -1);
                end else begin
                    int l;
                    l = len_q.pop_front();
                    chk(edges == l, "R4", "falling edges per frame", edges, l);
                end
                edges     = 0;
                in_frame  = 1'b0;
                since_gap = 1;
            end
            prev_sclk = sclk;
        end
    end

    task automatic push_frame(input logic [31:0] w, input logic [1:0] s, input bit tag8);
        for (int i = 0; i < nbits(s); i++) begin
            exp_q.push_back(w[i]);
            tag_q.push_back(tag8);
        end
        len_q.push_back(nbits(s));
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!frame_done);
    endtask

    // Driver: called in the first gap cycle, before the capture edge
    task automatic send(input logic [31:0] w, input logic [1:0] s,
                        input int h, input int g, input bit disturb);
        din      <= w;
        size_sel <= s;
        half_per <= h[15:0];
        gap_len  <= g[15:0];
        cur_h    <= h;
        cur_g    <= g;
        push_frame(w, s, disturb);
        if (disturb) begin
            repeat (4) @(negedge clk);
            din      <= ~w;       // R8: change after capture
            size_sel <= 2'b10;
        end
        wait_done();
    endtask

    initial begin
        repeat (20000) @(negedge clk);
        chk(1'b0, "R9", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        din      = 32'h0000_00A5;
        size_sel = 2'b00;
        half_per = 16'd2;
        gap_len  = 16'd4;
        cur_h    = 2;
        cur_g    = 4;
        repeat (3) @(negedge clk);
        chk(sclk == 1'b1, "R1", "sclk in reset", int'(sclk), 1);
        chk(sdata == 1'b0, "R1", "sdata in reset", int'(sdata), 0);
        chk(frame_done == 1'b0, "R1", "frame_done in reset", int'(frame_done), 0);
        rst <= 1'b0;
        @(negedge clk);
        push_frame(32'h0000_00A5, 2'b00, 1'b0);
        wait_done();

        send(32'hFFFF_8001, 2'b01, 3, 2, 1'b0);   // R5 upper bits masked
        send(32'h8000_0000, 2'b10, 1, 0, 1'b0);   // R4 no trailing edge, gap 0
        send(32'h0000_0001, 2'b11, 0, 1, 1'b0);   // R6 half 0 acts as 1
        send(32'h0438_103A, 2'b10, 2, 5, 1'b0);
        send(32'h0000_00C3, 2'b00, 2, 3, 1'b1);   // R8 mid-frame change
        send(32'h0000_1234, 2'b01, 1, 2, 1'b0);

        // R1: reset in the middle of a frame
        din      <= 32'h0000_00FF;
        size_sel <= 2'b00;
        half_per <= 16'd2;
        gap_len  <= 16'd2;
        cur_h    <= 2;
        cur_g    <= 2;
        push_frame(32'h0000_00FF, 2'b00, 1'b0);
        repeat (9) @(negedge clk);
        rst <= 1'b1;
        repeat (2) @(negedge clk);
        chk(sclk == 1'b1, "R1", "sclk after mid-frame reset", int'(sclk), 1);
        chk(sdata == 1'b0, "R1", "sdata after mid-frame reset", int'(sdata), 0);
        chk(frame_done == 1'b0, "R1", "frame_done after mid-frame reset", int'(frame_done), 0);
        din <= 32'h0000_005A;
        rst <= 1'b0;
        @(negedge clk);
        push_frame(32'h0000_005A, 2'b00, 1'b0);
        wait_done();
        @(negedge clk);
        chk(exp_q.size() == 0, "R4", "bits left in queue", exp_q.size(), 0);
        finish_run();
    end
endmodule